// File: doc/BRIEF.md
# Programmable Clock Divider with Load Handshake and Domain Reset

This block derives a slower clock from its reference clock by an integer ratio held in a single 32-bit control word. Software places a ratio in the divider field and raises the load strobe. The block then switches its internal counter to the new ratio at the next boundary of the output period, so no runt pulse appears. A lock status bit drops when the strobe is written. It rises again once a complete output period at the new ratio has been produced.

The same control word carries an output enable and a domain-reset request. The enable gates the divided clock at period boundaries and holds it low while cleared. The reset request produces a fixed-length reset pulse towards a downstream domain; the request bit clears itself when the pulse ends. Build parameters set the divider field width, the bit that reports lock, the pulse length, and an optional hardware remap of small ratios that a given divider instance cannot produce.

Top module: `clkdiv_lock_top`

## Requirements
- R1: Control word layout: bit 0 enable, bit 1 reset request (reads 1 while the pulse runs), bit 2 load strobe (reads 1 while a load is pending), bits 4 upward hold the DIV_W-bit divider field, and lock reads at bit 31 (bit 27 when LOCK_ALT=1). All other bits read 0. After reset the word reads only the lock bit set.
- R2: With effective ratio N = max(field,1), the output period is N reference cycles: high for floor(N/2) cycles, then low for the rest. With N=1 the output follows the reference clock.
- R3: Every write updates the stored divider field. The running ratio changes only after a write with the load strobe, and only at the next output period boundary.
- R4: The load strobe reads 1 from the write until the new ratio is taken into the counter, then clears itself.
- R5: A write with the load strobe set makes lock read 0 in the following cycle.
- R6: After a load, lock rises at the end of the first complete period at the new ratio, no later than old N plus new N cycles after the write, and always within 4*max(new,1) plus old N cycles.
- R7: With enable 0 the output stays low. Enable and disable take effect only at period boundaries, so the first and last high pulses are full length.
- R8: SKIP_MODE=1 stores a written field value of 1 as 0. SKIP_MODE=2 stores 1 and 2 as 0 and stores 3 as 4. Other values are stored unchanged, and the stored value is what reads back.
- R9: Writing 1 to the reset request bit asserts dom_rst_o for exactly RST_CYCLES cycles, starting the cycle after the write. A further request during a running pulse neither restarts nor extends it.
- R10: A single write that clears enable and sets the load strobe loads the new ratio while the output is low. Lock rises within the R6 bound, and a later enable runs at the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Writes wr_data into the control word this cycle |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value including lock |
| clk_out | output | 1 | Divided, gated clock |
| dom_rst_o | output | 1 | Active-high reset pulse to the downstream domain |

## Verification
The load strobe of a new write can land in the same cycle as the counter takes in an earlier pending ratio. In that case the new strobe must keep the load pending and keep lock low, rather than being lost. The bench provokes this by running at ratio 1, where every cycle is a period boundary, and issuing two strobed writes in consecutive cycles. It judges the result by the lock bit staying low after the second write, then rising, and by the measured high and low phase lengths matching the second ratio rather than the first.

// File: rtl/clkdiv_lock_pkg.sv
// Shared control-word bit positions for the clock divider.
// Assumes a 32-bit control word; the divider field starts at FIELD_LSB.
package clkdiv_lock_pkg;
    localparam int CTL_EN        = 0;
    localparam int CTL_RST       = 1;
    localparam int CTL_LOAD      = 2;
    localparam int FIELD_LSB     = 4;
    localparam int LOCK_POS_MAIN = 31;
    localparam int LOCK_POS_ALT  = 27;
    localparam int WORD_W        = 32;

    typedef enum int {
        SKIP_NONE  = 0,
        SKIP_ONE   = 1,
        SKIP_UPTO3 = 2
    } skip_mode_e;
endpackage

// File: rtl/clkdiv_lock_regs.sv
// Control register state: enable, staged divider field and load-pending flag.
// Assumes apply_i pulses for one cycle when the core takes in the staged value.
// A write and an apply in the same cycle leave the load pending if the write strobes.
module clkdiv_lock_regs #(
    parameter int DIV_W     = 8,
    parameter int SKIP_MODE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_en_bit,
    input  logic             wr_load_bit,
    input  logic [DIV_W-1:0] wr_field,
    input  logic             apply_i,
    output logic             en_o,
    output logic [DIV_W-1:0] stage_o,
    output logic             pend_o
);
    logic [DIV_W-1:0] fld_mapped;

    // Remap ratios this divider instance cannot produce.
    always_comb begin
        fld_mapped = wr_field;
        if (SKIP_MODE == 1) begin
            if (wr_field == DIV_W'(1)) fld_mapped = '0;
        end else if (SKIP_MODE == 2) begin
            if (wr_field == DIV_W'(1) || wr_field == DIV_W'(2)) fld_mapped = '0;
            else if (wr_field == DIV_W'(3)) fld_mapped = DIV_W'(4);
        end
    end

    // Hold enable, staged field and the pending-load flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= 1'b0;
            stage_o <= '0;
            pend_o  <= 1'b0;
        end else begin
            if (apply_i) pend_o <= 1'b0;
            if (wr_en) begin
                en_o    <= wr_en_bit;
                stage_o <= fld_mapped;
                if (wr_load_bit) pend_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkdiv_lock_core.sv
// Free-running period counter, boundary-aligned ratio switch, output gating and lock.
// Assumes the counter runs whether or not the output is enabled, so every load
// and every enable change is taken only at a period boundary.
module clkdiv_lock_core #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] stage_i,
    input  logic             pend_i,
    input  logic             load_req_i,
    output logic             apply_o,
    output logic             lock_o,
    output logic             clk_o
);
    logic [DIV_W-1:0] cnt_q, div_q, n_act, cnt_nx, div_nx, n_nx;
    logic             en_eff_q, en_nx, phase_q, phase_nx, last, armed_q, gate1_q;

    // Effective ratio and period boundary detection.
    always_comb begin
        n_act    = (div_q == '0) ? DIV_W'(1) : div_q;
        last     = (cnt_q == n_act - DIV_W'(1));
        apply_o  = last && pend_i;
        cnt_nx   = last ? '0 : cnt_q + DIV_W'(1);
        div_nx   = apply_o ? stage_i : div_q;
        en_nx    = last ? en_i : en_eff_q;
        n_nx     = (div_nx == '0) ? DIV_W'(1) : div_nx;
        phase_nx = en_nx && (cnt_nx < (n_nx >> 1));
    end

    // Advance the counter, switch ratio and enable at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            div_q    <= '0;
            en_eff_q <= 1'b0;
            phase_q  <= 1'b0;
        end else begin
            cnt_q    <= cnt_nx;
            div_q    <= div_nx;
            en_eff_q <= en_nx;
            phase_q  <= phase_nx;
        end
    end

    // Lock drops on a strobe and rises after one full period at the new ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_o  <= 1'b1;
            armed_q <= 1'b0;
        end else if (load_req_i) begin
            lock_o  <= 1'b0;
            armed_q <= 1'b0;
        end else if (apply_o) begin
            armed_q <= 1'b1;
        end else if (armed_q && last) begin
            lock_o  <= 1'b1;
            armed_q <= 1'b0;
        end
    end

    // Pass-through gate for ratio 1, updated while the reference clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) gate1_q <= 1'b0;
        else        gate1_q <= en_eff_q && (n_act == DIV_W'(1));
    end

    assign clk_o = phase_q | (clk & gate1_q);
endmodule

// File: rtl/clkdiv_lock_rstgen.sv
// Fixed-length downstream reset pulse generator.
// Assumes start_i is a one-cycle write qualifier; requests during a pulse are dropped.
module clkdiv_lock_rstgen #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    logic [CW-1:0] left_q;

    // Load the pulse length on an idle request and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)                         left_q <= '0;
        else if (start_i && left_q == '0)   left_q <= CW'(RST_CYCLES);
        else if (left_q != '0)              left_q <= left_q - CW'(1);
    end

    assign busy_o = (left_q != '0);
endmodule

// File: rtl/clkdiv_lock_top.sv
// Register-controlled integer clock divider with load/lock handshake and
// a downstream reset pulse. Assumes all control accesses are synchronous to clk
// and DIV_W leaves the field clear of the lock bit (DIV_W <= 23).
module clkdiv_lock_top #(
    parameter int DIV_W      = 8,
    parameter int SKIP_MODE  = 0,
    parameter bit LOCK_ALT   = 1'b0,
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        clk_out,
    output logic        dom_rst_o
);
    import clkdiv_lock_pkg::*;

    localparam int LOCK_POS = LOCK_ALT ? LOCK_POS_ALT : LOCK_POS_MAIN;

    logic             en_q, pend_q, apply, lock, load_req;
    logic [DIV_W-1:0] stage_q;
    logic             unused_wr_bits;

    assign load_req       = wr_en && wr_data[CTL_LOAD];
    assign unused_wr_bits = ^wr_data;

    clkdiv_lock_regs #(.DIV_W(DIV_W), .SKIP_MODE(SKIP_MODE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_en_bit  (wr_data[CTL_EN]),
        .wr_load_bit(wr_data[CTL_LOAD]),
        .wr_field   (wr_data[FIELD_LSB +: DIV_W]),
        .apply_i    (apply),
        .en_o       (en_q),
        .stage_o    (stage_q),
        .pend_o     (pend_q)
    );

    clkdiv_lock_core #(.DIV_W(DIV_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_q),
        .stage_i   (stage_q),
        .pend_i    (pend_q),
        .load_req_i(load_req),
        .apply_o   (apply),
        .lock_o    (lock),
        .clk_o     (clk_out)
    );

    clkdiv_lock_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(wr_en && wr_data[CTL_RST]),
        .busy_o (dom_rst_o)
    );

    // Assemble the read view of the control word.
    always_comb begin
        rd_data                       = '0;
        rd_data[CTL_EN]               = en_q;
        rd_data[CTL_RST]              = dom_rst_o;
        rd_data[CTL_LOAD]             = pend_q;
        rd_data[FIELD_LSB +: DIV_W]   = stage_q;
        rd_data[LOCK_POS]             = lock;
    end
endmodule

// File: rtl/clkdiv_lock_chk.sv
// Protocol checker for clkdiv_lock_top, attached to every instance by bind.
// Observes only the top-level ports; window lengths are tracked with counters.
module clkdiv_lock_chk #(
    parameter int DIV_W      = 8,
    parameter int SKIP_MODE  = 0,
    parameter bit LOCK_ALT   = 1'b0,
    parameter int RST_CYCLES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        dom_rst_o
);
    localparam int LOCK_POS   = LOCK_ALT ? 27 : 31;
    localparam int LOCK_LIMIT = 2 * (2 ** DIV_W) + 4;
    localparam int WW         = DIV_W + 3;
    localparam int RW         = $clog2(RST_CYCLES + 2) + 1;

    logic [WW-1:0] wait_q;
    logic [RW-1:0] rlen_q;
    logic          unused_chk_bits;
    logic [DIV_W-1:0] fld;

    assign unused_chk_bits = ^{wr_data, rd_data};
    assign fld             = rd_data[4 +: DIV_W];

    // Count cycles with lock low since the latest strobed write.
    always_ff @(posedge clk) begin
        if (!rst_n || (wr_en && wr_data[2]) || rd_data[LOCK_POS]) wait_q <= '0;
        else if (wait_q != '1)                                    wait_q <= wait_q + WW'(1);
    end

    // Count the length of the current reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !dom_rst_o) rlen_q <= '0;
        else if (rlen_q != '1)    rlen_q <= rlen_q + RW'(1);
    end

    assert_lock_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2]) |=> !rd_data[LOCK_POS]);

    assert_lock_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wait_q) <= LOCK_LIMIT);

    assert_pulse_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rlen_q) <= RST_CYCLES);

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_rst_o) |-> $past(wr_en && wr_data[1]));

    assert_remap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (SKIP_MODE == 0) || (fld != DIV_W'(1)));

    assert_remap_upto3_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (SKIP_MODE != 2) || (fld != DIV_W'(2) && fld != DIV_W'(3)));
endmodule

bind clkdiv_lock_top clkdiv_lock_chk #(
    .DIV_W(DIV_W), .SKIP_MODE(SKIP_MODE), .LOCK_ALT(LOCK_ALT), .RST_CYCLES(RST_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .dom_rst_o(dom_rst_o)
);

// File: tb/tb_clkdiv_lock_top.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_clkdiv_lock_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  we = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1, rd2;
    logic        co0, co1, co2, dr0, dr1, dr2;
    int          errors = 0;
    int          checks = 0;
    int          cur_n = 1;

    always #5 clk = ~clk;

    clkdiv_lock_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(we[0]), .wr_data(wdata),
        .rd_data(rd0), .clk_out(co0), .dom_rst_o(dr0));

    clkdiv_lock_top #(.DIV_W(4), .SKIP_MODE(2), .LOCK_ALT(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(we[1]), .wr_data(wdata),
        .rd_data(rd1), .clk_out(co1), .dom_rst_o(dr1));

    clkdiv_lock_top #(.DIV_W(4), .SKIP_MODE(1)) dut_c (
        .clk(clk), .rst_n(rst_n), .wr_en(we[2]), .wr_data(wdata),
        .rd_data(rd2), .clk_out(co2), .dom_rst_o(dr2));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input bit en, input bit rq, input bit ld, input int f);
        return (32'(f) << 4) | (32'(ld) << 2) | (32'(rq) << 1) | 32'(en);
    endfunction

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        wdata = d;
        we[sel] = 1'b1;
        @(negedge clk);
        we = '0;
    endtask

    task automatic wait_lock(input int limit, output int took);
        took = -1;
        for (int i = 1; i <= limit; i++) begin
            if (rd0[31]) begin
                took = i;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic measure(output int hi, output int lo);
        logic prev;
        hi = 0;
        lo = 0;
        prev = co0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!prev && co0) break;
            prev = co0;
        end
        hi = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (co0) hi++; else break;
        end
        lo = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!co0) lo++; else break;
        end
    endtask

    // Strobed load followed by lock wait and ratio measurement.
    task automatic load_and_check(input bit en, input int f, input string tag);
        int took, hi, lo, n;
        n = (f == 0) ? 1 : f;
        wr(0, ctl(en, 1'b0, 1'b1, f));
        chk(rd0[31] == 1'b0, {"R5 lock low after strobe ", tag}, rd0[31], 0);
        chk(rd0[2] == 1'b1, {"R4 strobe pending ", tag}, rd0[2], 1);
        wait_lock(4 * n + cur_n + 2, took);
        chk(took > 0, {"R6 lock within bound ", tag}, took, 4 * n + cur_n + 2);
        chk(rd0[2] == 1'b0, {"R4 strobe self-clear ", tag}, rd0[2], 0);
        chk(rd0[4 +: 8] == 8'(f), {"R1 field readback ", tag}, rd0[4 +: 8], f);
        cur_n = n;
        if (en && n > 1) begin
            measure(hi, lo);
            chk(hi == n / 2, {"R2 high phase ", tag}, hi, n / 2);
            chk(lo == n - n / 2, {"R2 low phase ", tag}, lo, n - n / 2);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(rd0 == 32'h8000_0000, "R1 reset word main", rd0, 32'h8000_0000);
        chk(rd1 == 32'h0800_0000, "R1 reset word alt lock", rd1, 32'h0800_0000);
        chk(co0 == 1'b0 && dr0 == 1'b0, "R7 output low after reset", co0, 0);
    endtask

    task automatic t_ratios;
        load_and_check(1'b1, 2, "n2");
        load_and_check(1'b1, 3, "n3");
        load_and_check(1'b1, 4, "n4");
        load_and_check(1'b1, 7, "n7");
        load_and_check(1'b1, 4, "n4b");
    endtask

    task automatic t_hold;
        int hi, lo;
        wr(0, ctl(1'b1, 1'b0, 1'b0, 6));
        repeat (10) @(negedge clk);
        measure(hi, lo);
        chk(hi == 2 && lo == 2, "R3 no change without strobe", hi * 10 + lo, 22);
        chk(rd0[4 +: 8] == 8'd6 && rd0[31], "R3 staged field and lock kept", rd0[4 +: 8], 6);
        load_and_check(1'b1, 6, "R3 strobed n6");
    endtask

    task automatic t_div1;
        int ones, zeros;
        load_and_check(1'b1, 0, "R2 field0");
        repeat (3) @(negedge clk);
        ones = 0;
        zeros = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2;
            if (co0) ones++;
            @(negedge clk); #2;
            if (!co0) zeros++;
        end
        chk(ones == 8 && zeros == 8, "R2 ratio 1 follows reference", ones * 10 + zeros, 88);
        load_and_check(1'b1, 1, "R2 field1");
    endtask

    task automatic t_collide;
        int took, hi, lo;
        @(negedge clk);
        wdata = ctl(1'b1, 1'b0, 1'b1, 3);
        we[0] = 1'b1;
        @(negedge clk);
        wdata = ctl(1'b1, 1'b0, 1'b1, 5);
        @(negedge clk);
        we = '0;
        chk(rd0[31] == 1'b0 && rd0[2] == 1'b1, "R4 back-to-back strobe kept pending", rd0[2], 1);
        wait_lock(4 * 5 + 3 + 4, took);
        chk(took > 0, "R6 lock after colliding loads", took, 27);
        measure(hi, lo);
        chk(hi == 2 && lo == 3, "R3 second ratio wins", hi * 10 + lo, 23);
        cur_n = 5;
    endtask

    task automatic t_gate;
        int highs, hi, lo;
        wr(0, ctl(1'b0, 1'b0, 1'b0, 5));
        repeat (12) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (co0) highs++;
            @(posedge clk); #2;
            if (co0) highs++;
        end
        chk(highs == 0, "R7 output held low when disabled", highs, 0);
        wr(0, ctl(1'b1, 1'b0, 1'b0, 5));
        measure(hi, lo);
        chk(hi == 2 && lo == 3, "R7 first pulse full length", hi * 10 + lo, 23);
    endtask

    task automatic t_gated_load;
        int took, highs, hi, lo;
        wr(0, ctl(1'b0, 1'b0, 1'b1, 9));
        wait_lock(4 * 9 + cur_n + 2, took);
        chk(took > 0, "R10 lock after gated load", took, 4 * 9 + cur_n + 2);
        chk(rd0[0] == 1'b0 && rd0[4 +: 8] == 8'd9, "R10 enable clear, field 9", rd0[4 +: 8], 9);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (co0) highs++;
        end
        chk(highs == 0, "R10 output low while loading disabled", highs, 0);
        cur_n = 9;
        wr(0, ctl(1'b1, 1'b0, 1'b0, 9));
        measure(hi, lo);
        chk(hi == 4 && lo == 5, "R10 enabled at loaded ratio", hi * 10 + lo, 45);
    endtask

    task automatic t_remap;
        wr(1, ctl(1'b0, 1'b0, 1'b0, 1));
        chk(rd1[4 +: 4] == 4'd0, "R8 mode2 1->0", rd1[4 +: 4], 0);
        wr(1, ctl(1'b0, 1'b0, 1'b0, 2));
        chk(rd1[4 +: 4] == 4'd0, "R8 mode2 2->0", rd1[4 +: 4], 0);
        wr(1, ctl(1'b0, 1'b0, 1'b0, 3));
        chk(rd1[4 +: 4] == 4'd4, "R8 mode2 3->4", rd1[4 +: 4], 4);
        wr(1, ctl(1'b0, 1'b0, 1'b0, 5));
        chk(rd1[4 +: 4] == 4'd5, "R8 mode2 5 kept", rd1[4 +: 4], 5);
        wr(2, ctl(1'b0, 1'b0, 1'b0, 1));
        chk(rd2[4 +: 4] == 4'd0, "R8 mode1 1->0", rd2[4 +: 4], 0);
        wr(2, ctl(1'b0, 1'b0, 1'b0, 2));
        chk(rd2[4 +: 4] == 4'd2, "R8 mode1 2 kept", rd2[4 +: 4], 2);
    endtask

    task automatic t_rst_pulse;
        int cnt, first;
        wr(0, ctl(1'b1, 1'b1, 1'b0, 9));
        first = dr0 && rd0[1];
        cnt = dr0 ? 1 : 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (dr0) cnt++;
        end
        chk(first == 1, "R9 pulse starts after write", first, 1);
        chk(cnt == 16, "R9 pulse length", cnt, 16);
        chk(rd0[1] == 1'b0, "R9 request self-clears", rd0[1], 0);
        cnt = 0;
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk);
                    if (dr0) cnt++;
                end
            end
            begin
                wr(0, ctl(1'b1, 1'b1, 1'b0, 9));
                repeat (5) @(negedge clk);
                wr(0, ctl(1'b1, 1'b1, 1'b0, 9));
            end
        join
        chk(cnt == 16, "R9 repeat request does not extend", cnt, 16);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R6 watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ratios();
        t_hold();
        t_div1();
        t_collide();
        t_gate();
        t_gated_load();
        t_remap();
        t_rst_pulse();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule